// File: doc/BRIEF.md
# Timed Click Count Detector

This block watches one single-bit input and decides whether a burst of exactly N complete pulses happens inside a time window of programmable length. The first rising edge seen while the block is idle opens the window. While the window is open the block counts falling edges of the input. When the window closes, it compares that count with the programmed target N and, on an exact match, raises a result strobe for one clock cycle. It is meant for decoding single, double or triple presses of a button or contact, and for any other "so many pulses within so much time" gesture.

The window length is a count of ticks, and a tick is a one-cycle enable strobe. Tying the strobe high measures the window in clock cycles. Driving it from a slower timebase measures the window in coarser units. Before any edge is detected, the input passes through a two-stage synchronizer. A target of zero is a valid pattern: it means the input rose and stayed high for the whole window.

Top module: `clickwin`

## Requirements
- R1: While idle, a rising edge of the synchronized input opens a window with the tick count and the edge count both at zero.
- R2: A falling edge is counted when its synchronized form reaches the block no later than the clock edge on which the window closes, including the closing edge itself. Later falling edges are not counted.
- R3: When the window closes, `hit` goes high for exactly one cycle if and only if the falling-edge count equals `target_n`.
- R4: `target_n` = 0 is legal. It matches a window in which the input rose and produced no counted falling edge.
- R5: The window timer advances only on clock edges where `tick` is 1. The window closes on the tick that brings the elapsed count to `win_len`, so with `tick` held low the window never closes.
- R6: Rising edges that arrive while a window is open neither restart nor extend the window.
- R7: The edge counter is CNT_W bits wide. One falling edge beyond 2^CNT_W-1 sets a sticky overflow, and a window with overflow never produces `hit`.
- R8: After the compare the block returns to idle. A new window opens only on a fresh rising edge, and falling edges seen while idle are ignored.
- R9: The input is sampled by two flip-flops before edge detection. If the rising edge that opens a window is first captured on clock edge k, and tick is held high, `hit` is high in the cycle that follows clock edge k+2+`win_len`.
- R10: Synchronous active-high `rst` clears the synchronizer, the timer, the counter and `hit`, and abandons any open window without a result.
- R11: A `win_len` of 0 behaves as a window of one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Monitored asynchronous input |
| tick | input | 1 | Timebase enable strobe for the window timer |
| target_n | input | CNT_W | Required number of falling edges |
| win_len | input | WIN_W | Window length in ticks |
| hit | output | 1 | One-cycle strobe on an exact count match |

## Verification
Every result is timed from the clock edge that first captures the opening rising edge, called k here. The bench records k when it drives that edge, one clock before capture. With tick held high, the only legal moment for `hit` is the cycle after edge k+2+`win_len`. The bench counts every `hit` cycle and stores the cycle number of the last one, then checks both the count and that exact cycle after the pattern and a guard interval have finished, so an early, late or repeated strobe is caught. Falling edges placed exactly on, and one cycle past, the last counted edge test the window boundary. In the tick-gated test, the expected cycle is counted from the cycle in which `tick` is first raised.

// File: rtl/clickwin_pkg.sv
package clickwin_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_info_t;

    function automatic edge_info_t classify(input logic now_v, input logic prev_v);
        edge_info_t e;
        e.level = now_v;
        e.rise  = now_v & ~prev_v;
        e.fall  = ~now_v & prev_v;
        return e;
    endfunction

endpackage

// File: rtl/clickwin_sync.sv
module clickwin_sync
    import clickwin_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_in,
    output edge_info_t edges
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            prev_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            prev_q <= chain[STAGES-1];
        end
    end

    assign edges = classify(chain[STAGES-1], prev_q);
endmodule

// File: rtl/clickwin_timer.sv
module clickwin_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [WIN_W-1:0] win_len,
    output logic [WIN_W-1:0] elapsed,
    output logic             done
);
    localparam int EXT_W = WIN_W + 1;

    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, elapsed} + EXT_W'(1);
    assign done     = run && tick && (next_ext >= {1'b0, win_len});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            elapsed <= '0;
        end else if (run && tick && !done) begin
            elapsed <= next_ext[WIN_W-1:0];
        end
    end
endmodule

// File: rtl/clickwin_counter.sv
module clickwin_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] nxt_val,
    output logic             nxt_over,
    output logic             over
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] val;

    always_comb begin
        nxt_val  = val;
        nxt_over = over;
        if (inc) begin
            if (val == CNT_MAX) nxt_over = 1'b1;
            else                nxt_val  = val + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            val  <= '0;
            over <= 1'b0;
        end else begin
            val  <= nxt_val;
            over <= nxt_over;
        end
    end
endmodule

// File: rtl/clickwin.sv
module clickwin
    import clickwin_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WIN_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             tick,
    input  logic [CNT_W-1:0] target_n,
    input  logic [WIN_W-1:0] win_len,
    output logic             hit
);
    win_state_e       state;
    edge_info_t       edges;
    logic [WIN_W-1:0] elapsed;
    logic             win_done;
    logic             cnt_clear;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_nxt_over;
    logic             cnt_over;
    logic             match;

    clickwin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sig_in),
        .edges    (edges)
    );

    assign cnt_clear = (state == WIN_IDLE);
    assign cnt_inc   = (state == WIN_OPEN) && edges.fall;

    clickwin_timer #(.WIN_W(WIN_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .run     (state == WIN_OPEN),
        .tick    (tick),
        .win_len (win_len),
        .elapsed (elapsed),
        .done    (win_done)
    );

    clickwin_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (cnt_clear),
        .inc      (cnt_inc),
        .nxt_val  (cnt_nxt),
        .nxt_over (cnt_nxt_over),
        .over     (cnt_over)
    );

    assign match = !cnt_nxt_over && (cnt_nxt == target_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WIN_IDLE;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            unique case (state)
                WIN_IDLE: if (edges.rise) state <= WIN_OPEN;
                WIN_OPEN: if (win_done) begin
                    state <= WIN_IDLE;
                    hit   <= match;
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clickwin_chk.sv
module clickwin_chk
    import clickwin_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sig_in,
    input logic             tick,
    input win_state_e       state,
    input edge_info_t       edges,
    input logic [WIN_W-1:0] elapsed,
    input logic             win_done,
    input logic             cnt_over,
    input logic             hit
);
    p_hit_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    p_open_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_IDLE && edges.rise) |=> (state == WIN_OPEN && elapsed == '0));

    p_hit_after_window_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> (state == WIN_IDLE && $past(state) == WIN_OPEN));

    p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_IDLE && !edges.rise) |=> state == WIN_IDLE);

    p_timer_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_OPEN && !tick) |=> (state == WIN_OPEN && $stable(elapsed)));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_OPEN && tick && !win_done) |=> elapsed == $past(elapsed) + WIN_W'(1));

    p_over_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_OPEN && win_done && cnt_over) |=> !hit);

    p_sync_delay_r9: assert property (@(posedge clk) disable iff (rst)
        edges.rise |-> $past(sig_in, 2));
endmodule

bind clickwin clickwin_chk #(.WIN_W(WIN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (sig_in),
    .tick     (tick),
    .state    (state),
    .edges    (edges),
    .elapsed  (elapsed),
    .win_done (win_done),
    .cnt_over (cnt_over),
    .hit      (hit)
);

// File: tb/clickwin_bench.sv
module clickwin_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int WIN_W      = 16;
    localparam int NVEC       = 15;

    // columns: target, window, pulses, high cycles, low cycles
    localparam int VEC [NVEC][5] = '{
        '{1, 20, 1, 3, 2},
        '{2, 20, 1, 3, 2},
        '{3, 30, 3, 2, 2},
        '{2, 30, 3, 2, 2},
        '{0, 10, 0, 0, 0},
        '{1, 10, 0, 0, 0},
        '{0,  5, 1, 8, 1},
        '{1,  5, 1, 8, 1},
        '{15, 60, 15, 1, 1},
        '{15, 60, 16, 1, 1},
        '{0,  0, 0, 0, 0},
        '{2,  8, 2, 2, 2},
        '{1,  6, 1, 6, 1},
        '{1,  5, 1, 6, 1},
        '{0,  5, 1, 6, 1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sig_in = 1'b0;
    logic             tick = 1'b1;
    logic [CNT_W-1:0] target_n = '0;
    logic [WIN_W-1:0] win_len = '0;
    logic             hit;

    int cyc = 0;
    int hit_cnt = 0;
    int hit_at = -1;
    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    clickwin #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_clickwin (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (sig_in),
        .tick     (tick),
        .target_n (target_n),
        .win_len  (win_len),
        .hit      (hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (hit === 1'b1) begin
            hit_cnt = hit_cnt + 1;
            hit_at  = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vec(input int idx);
        int n, w, p, hi, lo, weff, k, falls_in, fpos, exp_hits;
        n = VEC[idx][0]; w = VEC[idx][1]; p = VEC[idx][2];
        hi = VEC[idx][3]; lo = VEC[idx][4];
        weff = (w == 0) ? 1 : w;
        falls_in = 0;
        for (int i = 1; i <= p; i++) begin
            fpos = i * hi + (i - 1) * lo;
            if (fpos <= weff) falls_in++;
        end
        exp_hits = (falls_in == n) ? 1 : 0;
        target_n = CNT_W'(n);
        win_len  = WIN_W'(w);
        hit_cnt = 0; hit_at = -1;
        @(negedge clk);
        sig_in = 1'b1;
        k = cyc + 1;
        for (int i = 1; i <= p; i++) begin
            wait_cycles(hi);
            sig_in = 1'b0;
            if (i < p) begin
                wait_cycles(lo);
                sig_in = 1'b1;
            end
        end
        while (cyc < k + 2 + weff + 3) @(negedge clk);
        sig_in = 1'b0;
        wait_cycles(8);
        check(hit_cnt == exp_hits, $sformatf("R3/R2/R4/R6/R7/R11 vec %0d hit count", idx),
              hit_cnt, exp_hits);
        if (exp_hits == 1)
            check(hit_at == k + 2 + weff, $sformatf("R9 vec %0d hit cycle", idx),
                  hit_at, k + 2 + weff);
    endtask

    initial begin
        int c0;
        wait_cycles(3);
        check(hit === 1'b0, "R10 hit low in reset", int'(hit), 0);
        rst = 1'b0;
        wait_cycles(4);
        check(hit === 1'b0, "R10 hit low after reset", int'(hit), 0);

        for (int v = 0; v < NVEC; v++) run_vec(v);

        // R5: window frozen while tick is low
        target_n = '0; win_len = WIN_W'(3); tick = 1'b0;
        hit_cnt = 0; hit_at = -1;
        @(negedge clk); sig_in = 1'b1;
        wait_cycles(50);
        check(hit_cnt == 0, "R5 no close without tick", hit_cnt, 0);
        tick = 1'b1; c0 = cyc;
        wait_cycles(10);
        check(hit_cnt == 1, "R5 close after ticks", hit_cnt, 1);
        check(hit_at == c0 + 3, "R5 close cycle", hit_at, c0 + 3);
        // R8: input still high after the compare opens nothing new
        hit_cnt = 0;
        wait_cycles(30);
        check(hit_cnt == 0, "R8 no window without new rise", hit_cnt, 0);
        sig_in = 1'b0;
        wait_cycles(10);
        check(hit_cnt == 0, "R8 idle falling edge ignored", hit_cnt, 0);

        // R10: reset abandons an open window
        target_n = '0; win_len = WIN_W'(20);
        hit_cnt = 0;
        @(negedge clk); sig_in = 1'b1;
        wait_cycles(5);
        rst = 1'b1; sig_in = 1'b0;
        wait_cycles(2);
        rst = 1'b0;
        wait_cycles(40);
        check(hit_cnt == 0, "R10 reset drops window", hit_cnt, 0);

        // R1: fresh rise after reset opens a normal window
        hit_cnt = 0; hit_at = -1;
        @(negedge clk); sig_in = 1'b1; c0 = cyc + 1;
        wait_cycles(30);
        check(hit_cnt == 1 && hit_at == c0 + 22, "R1 window after reset", hit_at, c0 + 22);
        sig_in = 1'b0;
        wait_cycles(5);
        done_flag = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule